// File: doc/BRIEF.md
# Link Pulse Burst Codec

This block carries a fixed-width code word over a link that only has single pulses. Each word is sent as one burst of pulse slots at even spacing. The even-numbered slots (0, 2, 4, ...) always carry a pulse, and these form the burst's clock. Each odd-numbered slot between two clock pulses carries one data bit. A pulse in that slot means 1, and an empty slot means 0. The transmit side takes a word and a start strobe. It drives one-cycle pulse strobes on a clock-cycle timebase, then waits out an inter-burst gap and reports done.

The receive side watches a one-cycle pulse-detect input. It measures the cycles since the last accepted pulse to tell a clock pulse from a data pulse, and it rebuilds the word from that. It then reports either a decoded word or a malformed burst. All intervals are parameters, so the burst can be scaled down in simulation: slot spacing `SLOT_SP` (so clock-to-clock spacing is `2*SLOT_SP`), inter-burst gap `GAP_CYC` and word width `WORD_W`.

The receiver uses two acceptance windows:
- The near window is `SLOT_SP` plus or minus `SLOT_SP/4`.
- The far window is `2*SLOT_SP` plus or minus `SLOT_SP/2`.

Top module: `pulse_burst_codec`

## Requirements
- R1: After reset, `txPulse`, `txBusy`, `txDone`, `rxValid` and `rxError` are 0 and `rxWord` is all zeros.
- R2: A start strobe is taken only while `txBusy` is low. `txBusy` rises on the edge that takes the start and falls on the edge that raises `txDone`. A start strobe while busy changes neither the pulses nor the timing.
- R3: A burst has `2*WORD_W+1` slots spaced `SLOT_SP` cycles apart. Slot 0 is output one cycle after the start is taken. Every even slot carries a pulse, and every pulse lasts exactly one cycle.
- R4: Slot `2i+1` carries bit i of the word, with a pulse meaning 1. Bit 0 is sent first. The selector field, word bits 4:0, therefore fills the first five data slots.
- R5: `txDone` is a one-cycle strobe `GAP_CYC` cycles after the last slot. No new burst can start before it.
- R6: A well-formed received burst raises `rxValid` for one cycle, `GAP_CYC` cycles after the edge that samples its last clock pulse. `rxWord` then holds the decoded word until the next valid burst.
- R7: Pulses whose spacing falls inside the near window (`SLOT_SP ± SLOT_SP/4`) or, after a clock pulse, inside the far window (`2*SLOT_SP ± SLOT_SP/2`) are accepted as a data pulse or the next clock pulse respectively.
- R8: When a clock pulse is missing (the far window, or the near window after a data pulse, expires with no pulse), `rxError` pulses and the word is discarded. `rxValid` stays low and `rxWord` keeps its old value.
- R9: A pulse outside every window flags `rxError` and discards the word. This includes a pulse after the last clock pulse but before the gap has elapsed.
- R10: After an error, the receiver waits for `GAP_CYC` cycles of silence and then decodes the next burst normally.
- R11: `rxValid` and `rxError` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one timebase unit |
| rstN | input | 1 | Active-low synchronous reset |
| txStart | input | 1 | Start strobe for a transmit burst |
| txWord | input | WORD_W | Word to send, captured with the start |
| rxPulse | input | 1 | One-cycle pulse-detect strobe from the line |
| txPulse | output | 1 | One-cycle transmit pulse strobe |
| txBusy | output | 1 | Burst or inter-burst gap in progress |
| txDone | output | 1 | One-cycle strobe at the end of the gap |
| rxValid | output | 1 | One-cycle strobe: `rxWord` holds a new word |
| rxError | output | 1 | One-cycle strobe: malformed burst discarded |
| rxWord | output | WORD_W | Last decoded word |

## Verification
The assertions rely on three assumptions about the inputs:
- `rxPulse` is a single-cycle strobe.
- `SLOT_SP` is large enough that the near and far windows do not overlap.
- `GAP_CYC` is longer than the far window.

The stimulus keeps to these. The receive input is either looped back from the transmitter or driven with generated trains. Those trains are built from nominal slot times with at most one deliberately shifted, dropped or added pulse, and each train is followed by at least three gap lengths of silence, so every burst starts from a receiver at rest.

// File: rtl/pbc_pkg.sv
package pbc_pkg;

  // Strobes issued by the control to the datapath, one cycle each.
  typedef struct packed {
    logic txLoad;       // capture word, clear slot timer
    logic txEmitFrame;  // emit a clock pulse
    logic txEmitData;   // emit the next data bit and shift
    logic txArmSlot;    // reload timer with slot spacing
    logic txArmGap;     // reload timer with inter-burst gap
    logic rxClear;      // clear the receive accumulator
    logic rxSetBit;     // set the indexed accumulator bit
    logic rxPublish;    // copy accumulator to output word
  } pbcStrobe_t;

  typedef enum logic [1:0] {TX_IDLE, TX_SEND, TX_GAP} txState_t;

  typedef enum logic [2:0] {
    RX_IDLE, RX_AFT_FRAME, RX_AFT_DATA, RX_TAIL, RX_RECOVER
  } rxState_t;

endpackage

// File: rtl/pbc_datapath.sv
module pbc_datapath
  import pbc_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int SLOT_SP = 8,
  parameter int GAP_CYC = 48
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  pbcStrobe_t                     stb,
  input  logic [WORD_W-1:0]              txWordIn,
  input  logic                           rxPulseIn,
  input  logic [$clog2(WORD_W)-1:0]      rxBitIdx,
  output logic                           txTimZero,
  output logic [$clog2(GAP_CYC+1)-1:0]   rxSince,
  output logic                           txPulse,
  output logic                           rxValid,
  output logic [WORD_W-1:0]              rxWord
);

  localparam int TIM_W   = $clog2(GAP_CYC + SLOT_SP + 1);
  localparam int SINCE_W = $clog2(GAP_CYC + 1);

  logic [TIM_W-1:0]  txTim;
  logic [WORD_W-1:0] txSh;
  logic [WORD_W-1:0] rxAcc;

  // Transmit slot / gap timer
  always_ff @(posedge clk) begin
    if (!rstN)              txTim <= '0;
    else if (stb.txLoad)    txTim <= '0;
    else if (stb.txArmSlot) txTim <= TIM_W'(SLOT_SP - 1);
    else if (stb.txArmGap)  txTim <= TIM_W'(GAP_CYC - 1);
    else if (txTim != '0)   txTim <= txTim - 1'b1;
  end

  assign txTimZero = (txTim == '0);

  // Transmit word shifter, LSB leaves first
  always_ff @(posedge clk) begin
    if (!rstN)               txSh <= '0;
    else if (stb.txLoad)     txSh <= txWordIn;
    else if (stb.txEmitData) txSh <= txSh >> 1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) txPulse <= 1'b0;
    else       txPulse <= stb.txEmitFrame | (stb.txEmitData & txSh[0]);
  end

  // Cycles since the last received pulse, saturating at the gap
  always_ff @(posedge clk) begin
    if (!rstN)                          rxSince <= '0;
    else if (rxPulseIn)                 rxSince <= SINCE_W'(1);
    else if (rxSince != SINCE_W'(GAP_CYC)) rxSince <= rxSince + 1'b1;
  end

  // Receive accumulator and published word
  always_ff @(posedge clk) begin
    if (!rstN)             rxAcc <= '0;
    else if (stb.rxClear)  rxAcc <= '0;
    else if (stb.rxSetBit) rxAcc[rxBitIdx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxWord  <= '0;
      rxValid <= 1'b0;
    end else begin
      rxValid <= stb.rxPublish;
      if (stb.rxPublish) rxWord <= rxAcc;
    end
  end

  // R3: a transmit pulse never lasts more than one cycle
  p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    txPulse |=> !txPulse);

  // R6: the valid strobe lasts one cycle
  p_valid_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R2: the captured word is only reloaded by an accepted start
  p_word_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.txLoad && !stb.txEmitData) |=> $stable(txSh));

endmodule

// File: rtl/pbc_control.sv
module pbc_control
  import pbc_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int SLOT_SP = 8,
  parameter int GAP_CYC = 48
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           txStart,
  input  logic                           rxPulseIn,
  input  logic                           txTimZero,
  input  logic [$clog2(GAP_CYC+1)-1:0]   rxSince,
  output pbcStrobe_t                     stb,
  output logic [$clog2(WORD_W)-1:0]      rxBitIdx,
  output logic                           txBusy,
  output logic                           txDone,
  output logic                           rxError
);

  localparam int LAST_SLOT = 2 * WORD_W;
  localparam int SLOT_W    = $clog2(LAST_SLOT + 1);
  localparam int LAST_FR   = WORD_W + 1;
  localparam int FR_W      = $clog2(LAST_FR + 1);
  localparam int IDX_W     = $clog2(WORD_W);
  localparam int SINCE_W   = $clog2(GAP_CYC + 1);
  localparam int NEAR_TOL  = SLOT_SP / 4;
  localparam int FAR_TOL   = SLOT_SP / 2;
  localparam int NEAR_MIN  = SLOT_SP - NEAR_TOL;
  localparam int NEAR_MAX  = SLOT_SP + NEAR_TOL;
  localparam int FAR_MIN   = 2 * SLOT_SP - FAR_TOL;
  localparam int FAR_MAX   = 2 * SLOT_SP + FAR_TOL;

  txState_t          txState;
  logic [SLOT_W-1:0] txSlot;
  rxState_t          rxState, rxNext;
  logic [FR_W-1:0]   frames, framesNext;
  logic              errNow;
  logic              nearHit, farHit, frameDone;

  // ---------------- transmit sequencing ----------------
  always_comb begin
    stb.txLoad      = 1'b0;
    stb.txEmitFrame = 1'b0;
    stb.txEmitData  = 1'b0;
    stb.txArmSlot   = 1'b0;
    stb.txArmGap    = 1'b0;
    case (txState)
      TX_IDLE: stb.txLoad = txStart;
      TX_SEND: if (txTimZero) begin
        stb.txEmitFrame = ~txSlot[0];
        stb.txEmitData  = txSlot[0];
        if (txSlot == SLOT_W'(LAST_SLOT)) stb.txArmGap = 1'b1;
        else                              stb.txArmSlot = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txState <= TX_IDLE;
      txSlot  <= '0;
      txDone  <= 1'b0;
    end else begin
      txDone <= 1'b0;
      case (txState)
        TX_IDLE: if (txStart) begin
          txState <= TX_SEND;
          txSlot  <= '0;
        end
        TX_SEND: if (txTimZero) begin
          if (txSlot == SLOT_W'(LAST_SLOT)) txState <= TX_GAP;
          else                              txSlot  <= txSlot + 1'b1;
        end
        TX_GAP: if (txTimZero) begin
          txState <= TX_IDLE;
          txDone  <= 1'b1;
        end
        default: txState <= TX_IDLE;
      endcase
    end
  end

  assign txBusy = (txState != TX_IDLE);

  // ---------------- receive decoding ----------------
  assign nearHit = (rxSince >= SINCE_W'(NEAR_MIN)) && (rxSince <= SINCE_W'(NEAR_MAX));
  assign farHit  = (rxSince >= SINCE_W'(FAR_MIN))  && (rxSince <= SINCE_W'(FAR_MAX));
  assign frameDone = ((frames + 1'b1) == FR_W'(LAST_FR));
  assign rxBitIdx  = IDX_W'(frames - 1'b1);

  always_comb begin
    rxNext        = rxState;
    framesNext    = frames;
    errNow        = 1'b0;
    stb.rxClear   = 1'b0;
    stb.rxSetBit  = 1'b0;
    stb.rxPublish = 1'b0;
    case (rxState)
      RX_IDLE: if (rxPulseIn) begin
        stb.rxClear = 1'b1;
        framesNext  = FR_W'(1);
        rxNext      = RX_AFT_FRAME;
      end
      RX_AFT_FRAME: begin
        if (rxPulseIn) begin
          if (nearHit) begin
            stb.rxSetBit = 1'b1;
            rxNext       = RX_AFT_DATA;
          end else if (farHit) begin
            framesNext = frames + 1'b1;
            rxNext     = frameDone ? RX_TAIL : RX_AFT_FRAME;
          end else begin
            errNow = 1'b1;
          end
        end else if (rxSince == SINCE_W'(FAR_MAX)) begin
          errNow = 1'b1;
        end
      end
      RX_AFT_DATA: begin
        if (rxPulseIn) begin
          if (nearHit) begin
            framesNext = frames + 1'b1;
            rxNext     = frameDone ? RX_TAIL : RX_AFT_FRAME;
          end else begin
            errNow = 1'b1;
          end
        end else if (rxSince == SINCE_W'(NEAR_MAX)) begin
          errNow = 1'b1;
        end
      end
      RX_TAIL: begin
        if (rxPulseIn) errNow = 1'b1;
        else if (rxSince == SINCE_W'(GAP_CYC)) begin
          stb.rxPublish = 1'b1;
          rxNext        = RX_IDLE;
        end
      end
      RX_RECOVER: if (!rxPulseIn && rxSince == SINCE_W'(GAP_CYC)) rxNext = RX_IDLE;
      default: rxNext = RX_IDLE;
    endcase
    if (errNow) rxNext = RX_RECOVER;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxState <= RX_IDLE;
      frames  <= '0;
      rxError <= 1'b0;
    end else begin
      rxState <= rxNext;
      frames  <= framesNext;
      rxError <= errNow;
    end
  end

  // R3: the slot counter never passes the last slot of a burst
  p_slot_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    (txState == TX_SEND) |-> (txSlot <= SLOT_W'(LAST_SLOT)));

  // R5: done is raised only as the transmitter returns to idle
  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    txDone |-> !txBusy && $past(txBusy));

  // R6: a word is published only after every clock pulse arrived
  p_publish_full_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.rxPublish |-> (frames == FR_W'(LAST_FR)));

  // R8: the clock pulse count stays inside one burst
  p_frames_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    frames <= FR_W'(LAST_FR));

endmodule

// File: rtl/pulse_burst_codec.sv
module pulse_burst_codec
  import pbc_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int SLOT_SP = 8,
  parameter int GAP_CYC = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txStart,
  input  logic [WORD_W-1:0] txWord,
  input  logic              rxPulse,
  output logic              txPulse,
  output logic              txBusy,
  output logic              txDone,
  output logic              rxValid,
  output logic              rxError,
  output logic [WORD_W-1:0] rxWord
);

  localparam int IDX_W   = $clog2(WORD_W);
  localparam int SINCE_W = $clog2(GAP_CYC + 1);

  pbcStrobe_t         stb;
  logic               txTimZero;
  logic [SINCE_W-1:0] rxSince;
  logic [IDX_W-1:0]   rxBitIdx;

  pbc_control #(.WORD_W(WORD_W), .SLOT_SP(SLOT_SP), .GAP_CYC(GAP_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .txStart(txStart), .rxPulseIn(rxPulse),
    .txTimZero(txTimZero), .rxSince(rxSince), .stb(stb), .rxBitIdx(rxBitIdx),
    .txBusy(txBusy), .txDone(txDone), .rxError(rxError)
  );

  pbc_datapath #(.WORD_W(WORD_W), .SLOT_SP(SLOT_SP), .GAP_CYC(GAP_CYC)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .txWordIn(txWord), .rxPulseIn(rxPulse),
    .rxBitIdx(rxBitIdx), .txTimZero(txTimZero), .rxSince(rxSince),
    .txPulse(txPulse), .rxValid(rxValid), .rxWord(rxWord)
  );

  // R11: a burst ends either decoded or discarded, never both
  p_valid_err_excl_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(rxValid && rxError));

endmodule

// File: tb/tb_pulse_burst_codec.sv
module tb_pulse_burst_codec;

  localparam int CLK_PERIOD = 10;
  localparam int W    = 16;
  localparam int SP   = 8;
  localparam int GAP  = 48;
  localparam int NTOL = SP / 4;
  localparam int LAST = 2 * W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txStart = 1'b0;
  logic [W-1:0] txWord = '0;
  logic rxInj = 1'b0;
  logic useLoop = 1'b0;
  logic txPulse, txBusy, txDone, rxValid, rxError;
  logic [W-1:0] rxWord;
  logic rxPulse;
  int nChk = 0;
  int nFail = 0;
  logic [W-1:0] lastGood = '0;

  assign rxPulse = useLoop ? txPulse : rxInj;

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_burst_codec #(.WORD_W(W), .SLOT_SP(SP), .GAP_CYC(GAP)) dut (
    .clk(clk), .rstN(rstN), .txStart(txStart), .txWord(txWord), .rxPulse(rxPulse),
    .txPulse(txPulse), .txBusy(txBusy), .txDone(txDone),
    .rxValid(rxValid), .rxError(rxError), .rxWord(rxWord)
  );

  task automatic check(string req, longint act, longint exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected transmit pulse seen at negedge m after the start edge
  function automatic logic expTx(logic [W-1:0] w, int m);
    int r = m - 2;
    int k;
    if (r < 0 || (r % SP) != 0) return 1'b0;
    k = r / SP;
    if (k > LAST) return 1'b0;
    if ((k % 2) == 0) return 1'b1;
    return w[(k-1)/2];
  endfunction

  task automatic runTx(logic [W-1:0] w, bit poke);
    int mDone = 2 + LAST * SP + GAP;
    int mValid = mDone + 1;
    int errP = 0, errD = 0, errB = 0, errV = 0, errE = 0;
    useLoop = 1'b1;
    @(negedge clk);
    txWord = w;
    txStart = 1'b1;
    for (int m = 1; m <= mValid + 2; m++) begin
      @(negedge clk);
      txStart = 1'b0;
      if (txPulse !== expTx(w, m)) errP++;
      if (txDone !== (m == mDone)) errD++;
      if (txBusy !== (m < mDone)) errB++;
      if (rxValid !== (m == mValid)) errV++;
      if (rxError !== 1'b0) errE++;
      if (poke && m == 40) begin
        txStart = 1'b1;
        txWord = ~w;
      end
    end
    check("R3 R4 slot pulses", errP, 0);
    check("R5 done strobe timing", errD, 0);
    check(poke ? "R2 busy window with start while busy" : "R2 busy window", errB, 0);
    check("R6 loopback valid timing", errV, 0);
    check("R11 no error on clean burst", errE, 0);
    check("R6 loopback word", rxWord, w);
    lastGood = w;
  endtask

  function automatic logic injAt(logic [W-1:0] w, int drop, int jitSlot, int jitAmt,
                                 int extra, int r);
    if (r == extra) return 1'b1;
    for (int k = 0; k <= LAST; k++) begin
      int t = k * SP + ((k == jitSlot) ? jitAmt : 0);
      logic present = ((k % 2) == 0) || w[(k-1)/2];
      if (k != drop && present && t == r) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic runInj(string req, logic [W-1:0] w, int drop, int jitSlot, int jitAmt,
                        int extra, bit expValid);
    int nV = 0, nE = 0, vAt = -1, nBoth = 0;
    int mValid = LAST * SP + GAP + 1;
    useLoop = 1'b0;
    for (int r = 0; r <= LAST * SP + 3 * GAP; r++) begin
      @(negedge clk);
      if (rxValid === 1'b1) begin nV++; vAt = r; end
      if (rxError === 1'b1) nE++;
      if (rxValid === 1'b1 && rxError === 1'b1) nBoth++;
      rxInj = injAt(w, drop, jitSlot, jitAmt, extra, r);
    end
    @(negedge clk);
    rxInj = 1'b0;
    check({req, " R11 exclusive strobes"}, nBoth, 0);
    if (expValid) begin
      check({req, " valid count"}, nV, 1);
      check({req, " valid cycle"}, vAt, mValid);
      check({req, " error count"}, nE, 0);
      check({req, " word"}, rxWord, w);
      lastGood = w;
    end else begin
      check({req, " error flagged"}, (nE > 0), 1);
      check({req, " no valid"}, nV, 0);
      check({req, " word kept"}, rxWord, lastGood);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 txPulse", txPulse, 0);
    check("R1 txBusy", txBusy, 0);
    check("R1 txDone", txDone, 0);
    check("R1 rxValid", rxValid, 0);
    check("R1 rxError", rxError, 0);
    check("R1 rxWord", rxWord, 0);

    // Transmit sweep with loopback: extremes, walking ones and zeros, mixed
    runTx('0, 1'b0);
    runTx('1, 1'b1);
    runTx(16'h0015, 1'b0);   // R4 selector bits only
    for (int i = 0; i < W; i++) runTx(W'(1) << i, (i % 5) == 0);
    for (int i = 0; i < W; i++) runTx(~(W'(1) << i), 1'b0);
    for (int i = 1; i <= 6; i++) runTx(W'(i * 40503), 1'b0);

    // Receiver with generated trains
    runInj("R6 clean train", 16'h0F0F, -1, -1, 0, -1, 1'b1);
    runInj("R7 late data pulse in near window", 16'h0F0F, -1, 3, NTOL, -1, 1'b1);
    runInj("R7 early clock pulse in near window", 16'h0F0F, -1, 4, -NTOL, -1, 1'b1);
    runInj("R7 late clock pulse in far window", 16'h0000, -1, 2, 2 * NTOL, -1, 1'b1);
    runInj("R9 data pulse beyond near window", 16'h0F0F, -1, 3, NTOL + 1, -1, 1'b0);
    runInj("R9 early stray pulse", 16'h0F0F, -1, -1, 0, 3, 1'b0);
    runInj("R8 missing clock pulse", 16'h0F0F, 10, -1, 0, -1, 1'b0);
    runInj("R8 missing clock after data", 16'h0F0F, 2, -1, 0, -1, 1'b0);
    runInj("R9 pulse inside tail gap", 16'h0F0F, -1, -1, 0, LAST * SP + 10, 1'b0);
    runInj("R10 clean train after errors", 16'hC3A5, -1, -1, 0, -1, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

endmodule